// File: doc/BRIEF.md
# Complementary PWM Pair with Turn-On Delay

This block drives the two switches of a half-bridge from one free-running period timer. On each enabled tick the timer steps from zero up to a programmed period value and then starts over, so one period lasts period+1 ticks. A primary output is logically active while the timer is below the duty value. A secondary output is logically active for the rest of the period.

Neither output goes high at the moment its logical window opens. Each output first waits a programmable number of ticks, from 0 to 127, and only then rises. Falling edges are never delayed. This leaves a gap after every hand-over in which both switches are off, which prevents shoot-through. When a window is no longer than the delay, that output stays low for the whole period.

Period, duty and delay are taken from the inputs only at a period boundary, or at any clock while the block is idle. Software can therefore write new values at any time without causing a torn period. The tick input is the time base. A clock cycle without a tick changes nothing.

Top module: `pwm_db_top`

## Requirements
- R1: While reset is asserted, or while `enable` is low, both outputs are low. The first period after `enable` rises starts at timer position 0 with freshly loaded settings.
- R2: On each tick the timer position advances by one. The position that follows position P (the loaded period) is 0, so every period is P+1 ticks long.
- R3: With loaded duty D and delay B, `drv_hi` is high exactly at positions t with B <= t < D.
- R4: `drv_lo` is high exactly at positions t with t >= D and t - D >= B (t <= P).
- R5: An output whose window is B ticks long or shorter stays low for the entire period. For `drv_hi` the window is min(D, P+1) ticks. For `drv_lo` it is P+1-D ticks.
- R6: `drv_hi` and `drv_lo` are never high in the same cycle.
- R7: With B = 0 and the block running, `drv_lo` is the exact inverse of `drv_hi`.
- R8: Period, duty and delay inputs take effect only at the tick that wraps the timer to 0, or while the block is idle. A change in mid-period leaves the current period unchanged.
- R9: A clock cycle in which `tick` is low changes neither the timer position nor either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base enable. The timer and the delay counters advance only when it is high. |
| enable | input | 1 | Run control. When low, the outputs are forced low and the counters are cleared. |
| period_in | input | CNT_W | Last timer position of a period (P) |
| duty_in | input | CNT_W | Length of the primary logical window (D) |
| dead_in | input | DB_W | Turn-on delay in ticks (B) |
| drv_hi | output | 1 | Primary drive, active high |
| drv_lo | output | 1 | Complementary drive, active high |

## Verification
Two functions can fall on the same tick. The period wrap loads new settings and restarts the primary delay count, while the secondary window closes. When D = 0, the wrap also restarts the secondary delay count. Both cases are provoked by sweeping every duty value from 0 to P+2, including the value that makes the secondary window open at position 0, against small periods and several delays, under an irregular tick pattern. Settings are also changed in mid-period. Every cycle is judged against an arithmetic window formula evaluated on a position counter kept by the bench. The formula gives the expected level of both outputs. The bench also checks that the outputs never overlap.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;

    // Identifies which half-bridge leg a gate instance serves
    typedef enum logic {
        SIDE_PRI = 1'b0,
        SIDE_SEC = 1'b1
    } side_e;

    localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/pwm_db_timebase.sv
module pwm_db_timebase #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DB_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DB_W-1:0]  dead_in,
    output logic             active_o,
    output logic [CNT_W-1:0] pos_o,
    output logic [CNT_W-1:0] duty_o,
    output logic [DB_W-1:0]  dead_o,
    output logic             pri_restart_o,
    output logic             sec_restart_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DB_W-1:0]  dead;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;
    logic      active;

    always_comb begin
        st_d   = st_q;
        wrap   = (st_q.pos == st_q.per);
        active = st_q.run && enable;
        if (!active) begin
            st_d.run  = enable;
            st_d.pos  = '0;
            st_d.per  = period_in;
            st_d.duty = duty_in;
            st_d.dead = dead_in;
        end else if (tick) begin
            if (wrap) begin
                st_d.pos  = '0;
                st_d.per  = period_in;
                st_d.duty = duty_in;
                st_d.dead = dead_in;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o      = active;
    assign pos_o         = st_q.pos;
    assign duty_o        = st_q.duty;
    assign dead_o        = st_q.dead;
    // Primary window reopens at position 0 only
    assign pri_restart_o = active && tick && wrap;
    // Secondary window (re)opens once the next position reaches the duty value
    assign sec_restart_o = active && tick && (wrap || (st_q.pos < st_q.duty));

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.pos <= st_q.per)); // R2

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !(tick && wrap)) |=> ($stable(st_q.per) && $stable(st_q.duty) && $stable(st_q.dead))); // R8

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(st_q.pos)); // R9

endmodule

// File: rtl/pwm_db_gate.sv
module pwm_db_gate #(
    parameter int unsigned DB_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            tick,
    input  logic            restart,
    input  logic            window,
    input  logic [DB_W-1:0] dead,
    output logic            drive_o
);

    typedef struct packed {
        logic [DB_W-1:0] cnt;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (restart) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != {DB_W{1'b1}}) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Rising edge waits for the delay count; falling edge follows the window
    assign drive_o = active && window && (st_q.cnt >= dead);

    AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !drive_o); // R1

endmodule

// File: rtl/pwm_db_top.sv
module pwm_db_top
    import pwm_db_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned DB_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [DB_W-1:0]  dead_in,
    output logic             drv_hi,
    output logic             drv_lo
);

    localparam int unsigned CMP_W = (CNT_W > DB_W) ? CNT_W + 1 : DB_W + 1;

    logic             active;
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] duty;
    logic [DB_W-1:0]  dead;
    logic             pri_restart;
    logic             sec_restart;
    logic             pri_window;
    logic [NUM_SIDES-1:0] side_drive;

    pwm_db_timebase #(
        .CNT_W (CNT_W),
        .DB_W  (DB_W)
    ) u_timebase (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .enable        (enable),
        .period_in     (period_in),
        .duty_in       (duty_in),
        .dead_in       (dead_in),
        .active_o      (active),
        .pos_o         (pos),
        .duty_o        (duty),
        .dead_o        (dead),
        .pri_restart_o (pri_restart),
        .sec_restart_o (sec_restart)
    );

    assign pri_window = (pos < duty);

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam side_e SIDE = side_e'(s);
        logic win;
        logic rst_win;
        if (SIDE == SIDE_PRI) begin : g_pri
            assign win     = pri_window;
            assign rst_win = pri_restart;
        end else begin : g_sec
            assign win     = !pri_window;
            assign rst_win = sec_restart;
        end
        pwm_db_gate #(
            .DB_W (DB_W)
        ) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active),
            .tick    (tick),
            .restart (rst_win),
            .window  (win),
            .dead    (dead),
            .drive_o (side_drive[s])
        );
    end

    assign drv_hi = side_drive[SIDE_PRI];
    assign drv_lo = side_drive[SIDE_SEC];

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_hi && drv_lo)); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!drv_hi && !drv_lo)); // R1

    AST_ZERO_DELAY_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (dead == '0)) |-> (drv_hi != drv_lo)); // R7

    AST_SHORT_PRI_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (CMP_W'(dead) >= CMP_W'(duty))) |-> !drv_hi); // R5

endmodule

// File: tb/pwm_db_top_tb.sv
module pwm_db_top_tb;

    localparam int CNT_W = 8;
    localparam int DB_W  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] period_in = '0;
    logic [CNT_W-1:0] duty_in = '0;
    logic [DB_W-1:0]  dead_in = '0;
    logic             drv_hi;
    logic             drv_lo;

    int n_checks = 0;
    int n_errors = 0;

    // Reference model state
    int m_run = 0, m_t = 0, m_p = 0, m_d = 0, m_b = 0;
    int m_chg = 0;          // mid-period change pending
    int m_wrapped = 0;
    int prev_hi = 0, prev_lo = 0, prev_steady = 0, last_tick = 0;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    pwm_db_top #(.CNT_W(CNT_W), .DB_W(DB_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (enable),
        .period_in (period_in),
        .duty_in   (duty_in),
        .dead_in   (dead_in),
        .drv_hi    (drv_hi),
        .drv_lo    (drv_lo)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (P=%0d D=%0d B=%0d t=%0d)",
                     req, act, exp, m_p, m_d, m_b, m_t);
        end
    endtask

    // One clock: update the model at the edge, then compare outputs mid-cycle
    task automatic step();
        int running, e_hi, e_lo;
        string thi, tlo;
        @(posedge clk);
        m_wrapped = 0;
        if (!rst_n) begin
            m_run = 0; m_t = 0; m_p = 0; m_d = 0; m_b = 0;
        end else if (!(m_run != 0 && enable)) begin
            m_run = enable ? 1 : 0;
            m_t = 0; m_p = period_in; m_d = duty_in; m_b = dead_in; m_chg = 0;
        end else if (tick) begin
            if (m_t == m_p) begin
                m_t = 0; m_p = period_in; m_d = duty_in; m_b = dead_in;
                m_chg = 0; m_wrapped = 1;
            end else begin
                m_t++;
            end
        end
        last_tick = tick;
        #2;
        running = (rst_n && m_run != 0 && enable) ? 1 : 0;
        e_hi = (running != 0 && m_t < m_d && m_t >= m_b) ? 1 : 0;
        e_lo = (running != 0 && m_t >= m_d && (m_t - m_d) >= m_b) ? 1 : 0;
        if (running == 0) begin
            thi = "R1"; tlo = "R1";
        end else if (m_chg != 0) begin
            thi = "R8"; tlo = "R8";
        end else if (m_wrapped != 0) begin
            thi = "R2"; tlo = "R2";
        end else if (m_b == 0) begin
            thi = "R7"; tlo = "R7";
        end else begin
            thi = (((m_d < m_p + 1) ? m_d : m_p + 1) <= m_b) ? "R5" : "R3";
            tlo = ((m_p + 1 - m_d) <= m_b) ? "R5" : "R4";
        end
        check(thi, int'(drv_hi), e_hi);
        check(tlo, int'(drv_lo), e_lo);
        check("R6", int'(drv_hi && drv_lo), 0);
        if (running != 0 && m_b == 0) check("R7", int'(drv_hi ^ drv_lo), 1);
        if (running != 0 && prev_steady != 0 && last_tick == 0) begin
            check("R9", int'(drv_hi), prev_hi);
            check("R9", int'(drv_lo), prev_lo);
        end
        prev_hi = drv_hi; prev_lo = drv_lo; prev_steady = running;
        @(negedge clk);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick = lfsr[0] | lfsr[1];
    endtask

    task automatic run_cfg(input int p, input int d, input int b, input int cycles);
        enable = 1'b0;
        step();
        period_in = CNT_W'(p); duty_in = CNT_W'(d); dead_in = DB_W'(b);
        enable = 1'b1;
        for (int i = 0; i < cycles; i++) step();
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        enable = 1'b1; period_in = 8'd4; duty_in = 8'd2;
        for (int i = 0; i < 3; i++) step();       // R1 reset holds outputs low
        rst_n = 1'b1;
        @(negedge clk);
        // Near-exhaustive sweep of small configurations
        for (int p = 1; p <= 5; p++)
            for (int d = 0; d <= p + 2; d++)
                for (int b = 0; b <= 4; b++)
                    run_cfg(p, d, b, 4 * (p + 1) + 4);
        // Wide configurations using large delays
        run_cfg(200, 150, 127, 500);
        run_cfg(250, 20, 100, 600);
        run_cfg(10, 3, 127, 60);
        // Mid-period change (R8): new settings wait for the wrap
        run_cfg(6, 2, 1, 3);
        period_in = 8'd3; duty_in = 8'd5; dead_in = 7'd0;
        m_chg = 1;
        for (int i = 0; i < 40; i++) step();
        // Disable in mid-run, then restart at position 0 (R1)
        run_cfg(7, 4, 2, 9);
        enable = 1'b0;
        step();
        step();
        enable = 1'b1;
        for (int i = 0; i < 20; i++) step();
        // Reset in mid-run (R1)
        rst_n = 1'b0;
        step();
        check("R1", int'(drv_hi | drv_lo), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) step();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule